// File: doc/BRIEF.md
# Fetch Target Buffer

This block sits in the instruction fetch stage. It holds a small set of entries, and each entry pairs the address of a branch instruction with the address that branch jumps to. In every fetch cycle the current program counter is compared against all stored branch addresses at once. If one matches and the separately supplied direction guess says the branch will be taken, fetch is steered to the stored target. In every other case fetch moves on to the next sequential word.

A later pipeline stage writes to the buffer when a branch resolves. If the branch address is already stored, only its target is rewritten. Otherwise a new entry is placed at the slot named by a round-robin pointer, which then moves to the following slot. The lookup is purely combinational, and writes take effect on the clock edge. A lookup in the same cycle as a write therefore still sees the old contents.

Top module: `fetch_target_buffer`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears every entry's valid bit, so lookups afterwards miss (`hit`=0) until an update installs an entry.
- R2: When `fetch_pc` equals a valid stored branch address, `hit`=1 and `hit_target` shows that entry's target; with `pred_taken`=1, `next_pc` equals that target.
- R3: On a hit with `pred_taken`=0, `next_pc` is `fetch_pc`+4 while `hit` stays 1.
- R4: On a miss, `hit`=0, `hit_target`=0 and `next_pc` is `fetch_pc`+4, whatever `pred_taken` is.
- R5: An update (`upd_en`=1) whose `upd_pc` matches a valid entry rewrites only that entry's target. No other entry is lost and the round-robin pointer does not move.
- R6: An update whose `upd_pc` matches no valid entry writes slot 0 first after reset, then slots 1, 2, and so on, wrapping to 0 after slot DEPTH-1. It replaces whatever that slot held.
- R7: A lookup in the same cycle as an update sees the contents from before the update; the new contents become visible from the next cycle.
- R8: The sequential next address is computed modulo 2^ADDR_W, so `fetch_pc`=0xFFFFFFFC gives `next_pc`=0 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| pred_taken | input | 1 | Direction guess for the instruction at fetch_pc |
| hit | output | 1 | fetch_pc matches a valid entry |
| hit_target | output | ADDR_W | Stored target on a hit, zero otherwise |
| next_pc | output | ADDR_W | Address to fetch next |
| upd_en | input | 1 | Write request from branch resolution |
| upd_pc | input | ADDR_W | Branch address to install or refresh |
| upd_target | input | ADDR_W | Target address to store |

## Verification
Lookups are tried with four patterns: a stored address guessed taken, the same address guessed not taken, an absent address with either guess, and the top-of-memory address. Together these separate the target path from the sequential path and catch a carry that does not wrap. The replacement order is seen only through eviction. The buffer is filled, one target is refreshed, and then two new branches are installed. Which older addresses stop hitting shows both that allocation follows slot order and that a refresh does not move the pointer. A lookup that coincides with a write to the same address tells a design that bypasses the write apart from one that returns the old contents.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
  typedef enum logic [1:0] {ACT_IDLE, ACT_REFRESH, ACT_ALLOC} ftb_act_e;

  function automatic int unsigned ring_next(input int unsigned cur, input int unsigned depth);
    return (cur + 1 >= depth) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/ftb_match.sv
module ftb_match #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [ADDR_W-1:0] key,
  input  logic [ADDR_W-1:0] tags [DEPTH],
  input  logic [DEPTH-1:0]  valid,
  output logic [DEPTH-1:0]  match_vec,
  output logic              any,
  output logic [IDX_W-1:0]  idx
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_vec[g] = valid[g] && (tags[g] == key);
  end

  assign any = |match_vec;

  always_comb begin
    idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ftb_store.sv
module ftb_store #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt,
  output logic [ADDR_W-1:0] tags [DEPTH],
  output logic [ADDR_W-1:0] tgts [DEPTH],
  output logic [DEPTH-1:0]  valid
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid[g] <= 1'b0;
      end else if (sel) begin
        valid[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tags[g] <= wr_tag;
        tgts[g] <= wr_tgt;
      end
    end
  end
endmodule

// File: rtl/ftb_ring.sv
module ftb_ring #(
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (adv) ptr <= IDX_W'(ftb_pkg::ring_next(int'(ptr), DEPTH));
  end
endmodule

// File: rtl/fetch_target_buffer.sv
module fetch_target_buffer #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              pred_taken,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_target,
  output logic [ADDR_W-1:0] next_pc,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target
);
  import ftb_pkg::*;

  function automatic logic [ADDR_W-1:0] seq_pc(input logic [ADDR_W-1:0] pc);
    return pc + ADDR_W'(4);
  endfunction

  logic [ADDR_W-1:0] tags [DEPTH];
  logic [ADDR_W-1:0] tgts [DEPTH];
  logic [DEPTH-1:0]  valid_vec;
  logic [DEPTH-1:0]  look_match_vec, upd_match_vec;
  logic              look_any, upd_any;
  logic [IDX_W-1:0]  look_idx, upd_idx, rr_ptr, wr_idx;
  logic              alloc_fire, refresh_fire, redirect;
  ftb_act_e          act;

  ftb_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_look (
    .key(fetch_pc), .tags(tags), .valid(valid_vec),
    .match_vec(look_match_vec), .any(look_any), .idx(look_idx));

  ftb_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_updm (
    .key(upd_pc), .tags(tags), .valid(valid_vec),
    .match_vec(upd_match_vec), .any(upd_any), .idx(upd_idx));

  always_comb begin
    if (!upd_en)     act = ACT_IDLE;
    else if (upd_any) act = ACT_REFRESH;
    else             act = ACT_ALLOC;
  end

  assign refresh_fire = (act == ACT_REFRESH);
  assign alloc_fire   = (act == ACT_ALLOC);
  assign wr_idx       = refresh_fire ? upd_idx : rr_ptr;

  ftb_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .adv(alloc_fire), .ptr(rr_ptr));

  ftb_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(upd_en), .wr_idx(wr_idx),
    .wr_tag(upd_pc), .wr_tgt(upd_target),
    .tags(tags), .tgts(tgts), .valid(valid_vec));

  assign hit        = look_any;
  assign hit_target = look_any ? tgts[look_idx] : '0;
  assign redirect   = look_any && pred_taken;
  assign next_pc    = redirect ? hit_target : seq_pc(fetch_pc);
endmodule

// File: rtl/ftb_checker.sv
module ftb_checker #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              pred_taken,
  input logic              hit,
  input logic [ADDR_W-1:0] hit_target,
  input logic [ADDR_W-1:0] next_pc,
  input logic              alloc_fire,
  input logic              refresh_fire,
  input logic [IDX_W-1:0]  rr_ptr,
  input logic [DEPTH-1:0]  valid_vec,
  input logic [DEPTH-1:0]  look_match_vec
);
  logic [IDX_W-1:0] ptr_after;
  assign ptr_after = IDX_W'(ftb_pkg::ring_next(int'(rr_ptr), DEPTH));

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_vec == '0));

  // R2
  taken_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pred_taken) |-> (next_pc == hit_target));

  // R3
  not_taken_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !pred_taken) |-> (next_pc == fetch_pc + ADDR_W'(4)));

  // R4
  miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (next_pc == fetch_pc + ADDR_W'(4) && hit_target == '0));

  // R5
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_match_vec));

  // R5
  refresh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_fire |=> ($stable(rr_ptr) && $stable(valid_vec)));

  // R6
  alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (rr_ptr == $past(ptr_after)));
endmodule

bind fetch_target_buffer ftb_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ftb_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
  .hit(hit), .hit_target(hit_target), .next_pc(next_pc),
  .alloc_fire(alloc_fire), .refresh_fire(refresh_fire), .rr_ptr(rr_ptr),
  .valid_vec(valid_vec), .look_match_vec(look_match_vec));

// File: tb/test_fetch_target_buffer.sv
module test_fetch_target_buffer;
  localparam int AW = 32;
  localparam int N  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0;
  logic          pred_taken = 1'b0;
  logic          hit;
  logic [AW-1:0] hit_target, next_pc;
  logic          upd_en = 1'b0;
  logic [AW-1:0] upd_pc = '0, upd_target = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fetch_target_buffer #(.ADDR_W(AW), .DEPTH(N)) i_fetch_target_buffer (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .hit(hit), .hit_target(hit_target), .next_pc(next_pc),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_target(upd_target));

  function automatic logic [AW-1:0] br_addr(input int i);
    return 32'h0000_1000 + AW'(i * 16);
  endfunction
  function automatic logic [AW-1:0] br_tgt(input int i);
    return 32'h0000_8000 + AW'(i * 256);
  endfunction

  // {pc, taken, exp_hit, exp_next}
  localparam logic [65:0] VEC [0:5] = '{
    {32'h0000_1030, 1'b1, 1'b1, 32'h0000_8300},
    {32'h0000_1030, 1'b0, 1'b1, 32'h0000_1034},
    {32'h0000_2000, 1'b1, 1'b0, 32'h0000_2004},
    {32'hFFFF_FFFC, 1'b1, 1'b0, 32'h0000_0000},
    {32'h0000_1070, 1'b1, 1'b1, 32'h0000_8700},
    {32'h0000_1000, 1'b1, 1'b1, 32'h0000_8000}
  };

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic look(input logic [AW-1:0] pc, input logic tk);
    @(negedge clk);
    fetch_pc = pc; pred_taken = tk;
    #1;
  endtask

  task automatic write(input logic [AW-1:0] pc, input logic [AW-1:0] tg);
    @(negedge clk);
    upd_en = 1'b1; upd_pc = pc; upd_target = tg;
    @(negedge clk);
    upd_en = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    look(32'h0000_1000, 1'b1);
    check("R1 hit in reset", AW'(hit), 0);
    check("R1 next in reset", next_pc, 32'h0000_1004);
    @(negedge clk); rst_n = 1'b1;
    look(32'h0000_1000, 1'b1);
    check("R1 hit after reset", AW'(hit), 0);
    check("R4 miss target zero", hit_target, 0);

    for (int i = 0; i < N; i++) write(br_addr(i), br_tgt(i));

    for (int v = 0; v < 6; v++) begin
      look(VEC[v][65:34], VEC[v][33]);
      check(VEC[v][32] ? (VEC[v][33] ? "R2 table hit" : "R3 table hit") : "R4/R8 table miss",
            AW'(hit), AW'(VEC[v][32]));
      check("R2/R3/R4/R8 table next", next_pc, VEC[v][31:0]);
    end
    look(br_addr(5), 1'b0);
    check("R2 hit_target on not-taken hit", hit_target, br_tgt(5));

    // R5: refresh slot 1 target
    write(br_addr(1), 32'h0000_CAFE);
    look(br_addr(1), 1'b1);
    check("R5 refreshed target", next_pc, 32'h0000_CAFE);
    for (int i = 0; i < N; i++) begin
      look(br_addr(i), 1'b1);
      check("R5 others kept", AW'(hit), 1);
    end

    // R6: next allocation replaces slot 0, then slot 1
    write(br_addr(8), br_tgt(8));
    look(br_addr(0), 1'b1);
    check("R6 slot0 evicted", AW'(hit), 0);
    look(br_addr(8), 1'b1);
    check("R6 new entry", next_pc, br_tgt(8));
    write(br_addr(9), br_tgt(9));
    look(br_addr(1), 1'b1);
    check("R6/R5 slot1 evicted, pointer not moved by refresh", AW'(hit), 0);
    look(br_addr(2), 1'b1);
    check("R6 slot2 kept", AW'(hit), 1);

    // R7: same-cycle lookup sees old contents
    @(negedge clk);
    fetch_pc = br_addr(2); pred_taken = 1'b1;
    upd_en = 1'b1; upd_pc = br_addr(2); upd_target = 32'h0000_BEEF;
    #1;
    check("R7 old target same cycle", next_pc, br_tgt(2));
    @(negedge clk);
    upd_en = 1'b0;
    #1;
    check("R7 new target next cycle", next_pc, 32'h0000_BEEF);
    @(negedge clk);
    fetch_pc = br_addr(12);
    upd_en = 1'b1; upd_pc = br_addr(12); upd_target = br_tgt(12);
    #1;
    check("R7 allocation not seen same cycle", AW'(hit), 0);
    @(negedge clk);
    upd_en = 1'b0;
    #1;
    check("R7 allocation seen next cycle", AW'(hit), 1);

    // R1: reset mid-run clears entries
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    look(br_addr(2), 1'b1);
    check("R1 cleared by reset", AW'(hit), 0);
    check("R1 sequential after reset", next_pc, br_addr(2) + 4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule